// File: doc/BRIEF.md
# Alternating Two-Bank Sample Demultiplexer

This block accepts one sample per clock from a fast sampling front end and spreads the stream over two output banks, A and B. Each sample is a 9-bit word made of an 8-bit Gray-coded value and an overrange flag. Samples are sent to the banks in strict turn, so each bank refreshes at half the input rate and holds its word for two clock periods. A receiver that runs at half speed can then take each bank on its own.

Each bank has a ready strobe and a complement of that strobe. The strobe toggles one clock after its bank register is written. Both edges of the strobe therefore land while the bank word is already settled, and a downstream capture register can use either edge. A low valid input freezes both banks and the turn-taking pointer. The block does not decode the Gray value.

Top module: `sample_bank_splitter`

## Requirements
- R1: A synchronous active-high reset clears both bank registers to zero, drives both ready strobes low and drives both complement strobes high.
- R2: The first valid sample after reset is written to bank A.
- R3: Valid samples are written to the banks in turn (A, B, A, B, ...), counting valid samples only.
- R4: A valid sample presented before a rising edge appears on its bank output after that edge, and the other bank keeps its value.
- R5: While the valid input is low, neither bank changes and the turn pointer holds, so the next valid sample goes to the bank that was next in turn.
- R6: A bank's ready strobe toggles on the clock edge that follows the edge that wrote that bank, and it does not change on the writing edge itself.
- R7: Each complement strobe is always the inverse of its ready strobe.
- R8: The sample word passes through unchanged: bits 7..0 carry the Gray value and bit 8 carries the overrange flag.
- R9: With valid held high, each bank keeps its word for two clock periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample valid |
| smp_word | input | 9 | Sample word: bit 8 is overrange, bits 7..0 are the Gray value |
| bank_a_q | output | 9 | Bank A word |
| bank_b_q | output | 9 | Bank B word |
| rdy_a | output | 1 | Bank A ready strobe (toggles) |
| rdy_a_n | output | 1 | Complement of the bank A strobe |
| rdy_b | output | 1 | Bank B ready strobe (toggles) |
| rdy_b_n | output | 1 | Complement of the bank B strobe |

## Verification
A sample presented before rising edge E appears on its bank output one cycle later, after edge E. Its ready strobe toggles only after edge E+1, so the strobe lags the data by exactly one cycle. The bench drives inputs on the falling edge and checks every output on the next falling edge. Its model applies a toggle that is pending from the previous step before it records the new write, so each check of a strobe happens one step after the matching data check. The checker states the same lag as properties: a write to a bank is followed by a stable strobe and then by a changed strobe, and the bank holds for one more cycle.

// File: rtl/split_pkg.sv
package split_pkg;
  localparam int NUM_BANKS = 2;
  localparam int SEL_W     = $clog2(NUM_BANKS);

  typedef enum logic [SEL_W-1:0] {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_sel_e;
endpackage

// File: rtl/bank_pointer.sv
module bank_pointer
  import split_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      adv,
  output bank_sel_e sel_q
);
  // Turn pointer: advances only on accepted samples.
  always_ff @(posedge clk) begin
    if (rst)
      sel_q <= BANK_A;
    else if (adv)
      sel_q <= (sel_q == BANK_A) ? BANK_B : BANK_A;
  end
endmodule

// File: rtl/bank_store.sv
module bank_store #(
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] q,
  output logic              loaded_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q        <= '0;
      loaded_q <= 1'b0;
    end else begin
      loaded_q <= load;
      if (load)
        q <= din;
    end
  end
endmodule

// File: rtl/ready_toggle.sv
module ready_toggle (
  input  logic clk,
  input  logic rst,
  input  logic pulse,
  output logic rdy,
  output logic rdy_n
);
  logic nxt;

  assign nxt = rdy ^ pulse;

  // Both polarities come from their own flops so neither trails the other.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy   <= 1'b0;
      rdy_n <= 1'b1;
    end else begin
      rdy   <= nxt;
      rdy_n <= ~nxt;
    end
  end
endmodule

// File: rtl/sample_bank_splitter.sv
module sample_bank_splitter
  import split_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            smp_vld,
  input  logic [DATA_W:0] smp_word,
  output logic [DATA_W:0] bank_a_q,
  output logic [DATA_W:0] bank_b_q,
  output logic            rdy_a,
  output logic            rdy_a_n,
  output logic            rdy_b,
  output logic            rdy_b_n
);
  localparam int WORD_W = DATA_W + 1;

  bank_sel_e         sel_q;
  logic [WORD_W-1:0] bank_q  [NUM_BANKS];
  logic              wr_q    [NUM_BANKS];
  logic              rdy_v   [NUM_BANKS];
  logic              rdy_n_v [NUM_BANKS];

  bank_pointer u_ptr (
    .clk   (clk),
    .rst   (rst),
    .adv   (smp_vld),
    .sel_q (sel_q)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic ld;
    assign ld = smp_vld && (sel_q == bank_sel_e'(SEL_W'(b)));

    bank_store #(.WORD_W(WORD_W)) u_store (
      .clk      (clk),
      .rst      (rst),
      .load     (ld),
      .din      (smp_word),
      .q        (bank_q[b]),
      .loaded_q (wr_q[b])
    );

    ready_toggle u_rdy (
      .clk   (clk),
      .rst   (rst),
      .pulse (wr_q[b]),
      .rdy   (rdy_v[b]),
      .rdy_n (rdy_n_v[b])
    );
  end

  assign bank_a_q = bank_q[0];
  assign bank_b_q = bank_q[1];
  assign rdy_a    = rdy_v[0];
  assign rdy_a_n  = rdy_n_v[0];
  assign rdy_b    = rdy_v[1];
  assign rdy_b_n  = rdy_n_v[1];
endmodule

// File: rtl/sample_bank_splitter_chk.sv
module sample_bank_splitter_chk #(
  parameter int DATA_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            smp_vld,
  input logic [DATA_W:0] smp_word,
  input logic [DATA_W:0] bank_a_q,
  input logic [DATA_W:0] bank_b_q,
  input logic            rdy_a,
  input logic            rdy_a_n,
  input logic            rdy_b,
  input logic            rdy_b_n
);
  // Independent turn tracker seen from the ports only.
  logic turn_b;
  always_ff @(posedge clk) begin
    if (rst)          turn_b <= 1'b0;
    else if (smp_vld) turn_b <= ~turn_b;
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (bank_a_q == '0 && bank_b_q == '0 && !rdy_a && rdy_a_n && !rdy_b && rdy_b_n));

  p_write_a_r3: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && !turn_b) |=> (bank_a_q == $past(smp_word) && $stable(bank_b_q)));

  p_write_b_r4: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && turn_b) |=> (bank_b_q == $past(smp_word) && $stable(bank_a_q)));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> ($stable(bank_a_q) && $stable(bank_b_q)));

  p_lag_a_r6: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && !turn_b) |=> $stable(rdy_a) ##1 (rdy_a != $past(rdy_a)));

  p_lag_b_r6: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && turn_b) |=> $stable(rdy_b) ##1 (rdy_b != $past(rdy_b)));

  p_compl_r7: assert property (@(posedge clk) disable iff (rst)
    (rdy_a_n == !rdy_a) && (rdy_b_n == !rdy_b));

  p_two_cycle_a_r9: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && !turn_b) |=> ##1 $stable(bank_a_q));
endmodule

bind sample_bank_splitter sample_bank_splitter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .smp_vld  (smp_vld),
  .smp_word (smp_word),
  .bank_a_q (bank_a_q),
  .bank_b_q (bank_b_q),
  .rdy_a    (rdy_a),
  .rdy_a_n  (rdy_a_n),
  .rdy_b    (rdy_b),
  .rdy_b_n  (rdy_b_n)
);

// File: tb/sample_bank_splitter_test.sv
`timescale 1ns/1ps
module sample_bank_splitter_test;
  localparam int DATA_W = 8;
  localparam int W      = DATA_W + 1;
  localparam int NV     = 12;

  // Vector: {valid, expected bank (0=A,1=B), word}
  localparam logic [W+1:0] VEC [NV] = '{
    {1'b1, 1'b0, 9'h000}, {1'b1, 1'b1, 9'h001}, {1'b1, 1'b0, 9'h003},
    {1'b0, 1'b0, 9'h0FF}, {1'b1, 1'b1, 9'h002}, {1'b0, 1'b0, 9'h1AA},
    {1'b0, 1'b0, 9'h055}, {1'b1, 1'b0, 9'h006}, {1'b1, 1'b1, 9'h007},
    {1'b1, 1'b0, 9'h105}, {1'b1, 1'b1, 9'h180}, {1'b1, 1'b0, 9'h0FF}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         smp_vld = 1'b0;
  logic [W-1:0] smp_word = '0;
  logic [W-1:0] bank_a_q, bank_b_q;
  logic         rdy_a, rdy_a_n, rdy_b, rdy_b_n;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] exp_q [2];
  logic         exp_r [2];
  logic         pend  [2];

  always #4 clk = ~clk;

  sample_bank_splitter #(.DATA_W(DATA_W)) uut (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_word(smp_word),
    .bank_a_q(bank_a_q), .bank_b_q(bank_b_q),
    .rdy_a(rdy_a), .rdy_a_n(rdy_a_n), .rdy_b(rdy_b), .rdy_b_n(rdy_b_n)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string dtag);
    check({dtag, " bank A"}, bank_a_q, exp_q[0]);
    check({dtag, " bank B"}, bank_b_q, exp_q[1]);
    check("R6 ready A", W'(rdy_a), W'(exp_r[0]));
    check("R6 ready B", W'(rdy_b), W'(exp_r[1]));
    check("R7 complement A", W'(rdy_a_n), W'(!exp_r[0]));
    check("R7 complement B", W'(rdy_b_n), W'(!exp_r[1]));
  endtask

  task automatic model_reset();
    for (int b = 0; b < 2; b++) begin
      exp_q[b] = '0; exp_r[b] = 1'b0; pend[b] = 1'b0;
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic step(input logic v, input logic bk, input logic [W-1:0] d, input string dtag);
    smp_vld  = v;
    smp_word = d;
    @(posedge clk);
    @(negedge clk);
    for (int b = 0; b < 2; b++) begin
      exp_r[b] = exp_r[b] ^ pend[b];
      pend[b]  = 1'b0;
    end
    if (v) begin
      exp_q[bk] = d;
      pend[bk]  = 1'b1;
    end
    check_all(dtag);
  endtask

  initial begin
    logic [W-1:0] held;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1 reset");
    rst = 1'b0;

    // Table walk: R2 (first write to A), R3 alternation, R4, R5 idle, R8 overrange.
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][W+1], VEC[i][W], VEC[i][W-1:0],
           VEC[i][W+1] ? "R3 R4 R8 table" : "R5 idle table");
    end
    step(1'b0, 1'b0, 9'h000, "R5 flush");

    // R9: continuous valid, bank A holds across two periods.
    step(1'b1, 1'b1, 9'h00C, "R3 run");
    step(1'b1, 1'b0, 9'h00D, "R3 run");
    held = bank_a_q;
    step(1'b1, 1'b1, 9'h00F, "R3 run");
    check("R9 bank A held two cycles", bank_a_q, held);
    step(1'b1, 1'b0, 9'h00E, "R3 run");
    check("R9 bank A refreshed", bank_a_q, 9'h00E);

    // Leave the pointer on bank B, then reset mid-stream.
    step(1'b1, 1'b1, 9'h00A, "R3 run");
    step(1'b1, 1'b0, 9'h00B, "R3 run");
    rst = 1'b1;
    smp_vld = 1'b1;
    smp_word = 9'h1FF;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    model_reset();
    check_all("R1 mid-stream reset");
    rst = 1'b0;
    step(1'b1, 1'b0, 9'h1C3, "R2 first after reset");
    check("R2 first sample in A", bank_a_q, 9'h1C3);
    check("R2 bank B untouched", bank_b_q, 9'h000);
    step(1'b0, 1'b0, 9'h0AA, "R5 idle");
    step(1'b1, 1'b1, 9'h181, "R8 overrange into B");
    check("R8 overrange bit 8 in B", W'(bank_b_q[8]), W'(1'b1));
    step(1'b0, 1'b0, 9'h000, "R5 flush");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule